// File: doc/BRIEF.md
# Transmit/Receive Buffer Descriptor Ring Manager

This block owns one table of 128 buffer descriptors that the transmit and receive sides of a frame controller share. Each entry holds two 32-bit words: a flags word and a buffer pointer word. A host-programmed transmit count N divides the table. Entries 0 to N-1 form the transmit ring and entries N to 127 form the receive ring. The block keeps the current transmit and receive positions. It decides when the transmit engine may begin a frame, and it writes status back into an entry when the engines report a completed transmit or an arrived frame. It also keeps three interrupt source bits, which are qualified by a mask into a single interrupt request.

In the flags word, bits 31:16 hold the length, bit 15 is ready (transmit) or empty (receive), bit 14 enables the completion interrupt and bit 13 is the wrap mark. Bit 8 and bits 7:0 are status bits that the block clears.

The host sees four registers through one select field: 0 is control (bit 0 enables receive, bit 1 enables transmit), 1 is the interrupt source (bit 0 transmit done, bit 2 receive done, bit 4 receive busy), 2 is the interrupt mask and 3 is the transmit count. Descriptor words are addressed as `{index, word}`, where word 0 is the flags word and word 1 is the pointer word.

The transmit side runs a three-state machine:
- TXS_OFF: transmit is disabled. It moves to TXS_SCAN when the transmit enable bit is set.
- TXS_SCAN: the block watches the current entry. It moves to TXS_SEND when the entry may be sent, and back to TXS_OFF when the enable bit is cleared.
- TXS_SEND: the frame is owned by the engine. It returns to TXS_SCAN on `tx_done`.

The receive side has two states:
- RXS_OFF: receive is blocked. It moves to RXS_LISTEN while receive is enabled and N is below 128.
- RXS_LISTEN: the block accepts `rx_frame` strobes. It falls back to RXS_OFF when that condition no longer holds.

Top module: `bd_ring_mgr`

## Requirements
- R1: After reset the transmit count reads 0x40, the transmit index is 0, the receive index is 0x40, and control, interrupt source, interrupt mask and `irq` are all 0. The flags and pointer words of every descriptor are 0.
- R2: A write of 0x80 or more to the transmit count (select 3) leaves the count unchanged. A smaller value replaces it, and register reads on select 0..3 return control, source, mask and count.
- R3: `tx_go` is high in TXS_SEND. TXS_SCAN moves to TXS_SEND only when transmit is enabled, N is nonzero, the current entry has bit 15 set and its length is greater than 4. While `tx_go` is high, `tx_len` and `tx_ptr` present the current entry's length and pointer.
- R4: `tx_done` while in TXS_SEND clears bits 15, 8 and 7:0 of the current flags word and keeps all other bits.
- R5: On that completion the transmit index becomes 0 if bit 13 was set. Otherwise it increments, and it returns to 0 when the incremented value reaches N.
- R6: An `rx_frame` in RXS_LISTEN whose current entry has bit 15 clear leaves the table and the receive index unchanged and sets source bit 4.
- R7: An `rx_frame` in RXS_LISTEN into an entry with bit 15 set writes `rx_len` into bits 31:16 and clears bits 15 and 8:0. The receive index then moves to N if bit 13 was set or the index was 127, and increments otherwise.
- R8: `rx_ready` is high only in RXS_LISTEN, which is entered one cycle after receive is enabled with N below 128. An `rx_frame` strobe outside RXS_LISTEN has no effect.
- R9: Source bit 0 (or bit 2) is set on a transmit (or receive) completion only when that entry's bit 14 is set. Writing ones to select 1 clears those source bits, and a source set in the same cycle wins. `irq` is the OR of source AND mask.
- R10: A control write that raises the transmit enable sets the transmit index to 0. One that raises the receive enable sets the receive index to N.
- R11: A host write that makes the current transmit entry sendable while in TXS_SCAN causes TXS_SEND on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write (0 control, 1 source, 2 mask, 3 count) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| desc_we | input | 1 | Descriptor word write strobe |
| desc_addr | input | 8 | Descriptor write address {index, word} |
| desc_wdata | input | 32 | Descriptor write data |
| desc_raddr | input | 8 | Descriptor read address {index, word} |
| desc_rdata | output | 32 | Descriptor word read data |
| tx_done | input | 1 | Transmit engine finished the current frame |
| tx_go | output | 1 | Current transmit entry is handed to the engine |
| tx_len | output | 16 | Length of the current transmit entry |
| tx_ptr | output | 32 | Buffer pointer of the current transmit entry |
| tx_idx | output | 7 | Current transmit index |
| rx_frame | input | 1 | A received frame is to be stored |
| rx_len | input | 16 | Length of the received frame |
| rx_ready | output | 1 | Receive side is accepting frames |
| rx_idx | output | 7 | Current receive index |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the engines behave:
- `tx_done` arrives only while `tx_go` is high.
- No host descriptor write targets the entry an engine is retiring in the same cycle.
- A control write that restarts an index does not coincide with a completion on that side.

The stimulus follows these rules by spacing host writes and engine strobes onto separate cycles. It changes N only while no frame is in flight, and it strobes `rx_frame` for a single cycle.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;

    // flags word bit positions
    localparam int FL_RDY  = 15;
    localparam int FL_IRQ  = 14;
    localparam int FL_WRAP = 13;

    // interrupt source bit positions
    localparam int SRC_TXB  = 0;
    localparam int SRC_RXB  = 2;
    localparam int SRC_BUSY = 4;
    localparam int SRCW     = SRC_BUSY + 1;

    // host register selects
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_SRC  = 2'd1;
    localparam logic [1:0] SEL_MASK = 2'd2;
    localparam logic [1:0] SEL_TXN  = 2'd3;

    // bits cleared when a transmit retires
    localparam logic [31:0] TX_RETIRE_CLR = 32'h0000_81FF;

    typedef enum logic [1:0] {
        TXS_OFF  = 2'd0,
        TXS_SCAN = 2'd1,
        TXS_SEND = 2'd2
    } tx_state_e;

    typedef enum logic {
        RXS_OFF    = 1'b0,
        RXS_LISTEN = 1'b1
    } rx_state_e;

endpackage

// File: rtl/bd_table.sv
module bd_table #(
    parameter  int NDESC = 128,
    localparam int IW    = $clog2(NDESC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [IW:0]   host_addr,
    input  logic [31:0]   host_wdata,
    input  logic [IW:0]   rd_addr,
    output logic [31:0]   rd_data,
    input  logic [IW-1:0] tx_idx,
    output logic [31:0]   tx_flags,
    output logic [31:0]   tx_ptr,
    input  logic          tx_we,
    input  logic [31:0]   tx_wdata,
    input  logic [IW-1:0] rx_idx,
    output logic [31:0]   rx_flags,
    input  logic          rx_we,
    input  logic [31:0]   rx_wdata
);

    logic [31:0] flags_all [NDESC];
    logic [31:0] ptr_all   [NDESC];

    for (genvar g = 0; g < NDESC; g++) begin : g_ent
        logic [31:0] fl_q;
        logic [31:0] pt_q;
        logic        hit_host;

        assign hit_host = host_we && (host_addr[IW:1] == IW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fl_q <= '0;
                pt_q <= '0;
            end else begin
                if (hit_host && !host_addr[0]) fl_q <= host_wdata;
                if (hit_host &&  host_addr[0]) pt_q <= host_wdata;
                // engine write-back overrides a host write to the same entry
                if (tx_we && tx_idx == IW'(g)) fl_q <= tx_wdata;
                if (rx_we && rx_idx == IW'(g)) fl_q <= rx_wdata;
            end
        end

        assign flags_all[g] = fl_q;
        assign ptr_all[g]   = pt_q;
    end

    assign rd_data  = rd_addr[0] ? ptr_all[rd_addr[IW:1]] : flags_all[rd_addr[IW:1]];
    assign tx_flags = flags_all[tx_idx];
    assign tx_ptr   = ptr_all[tx_idx];
    assign rx_flags = flags_all[rx_idx];

endmodule

// File: rtl/bd_tx_sched.sv
module bd_tx_sched
    import bd_ring_pkg::*;
#(
    parameter  int NDESC = 128,
    localparam int IW    = $clog2(NDESC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic [IW:0]   txn,
    input  logic          restart,
    input  logic [31:0]   cur_flags,
    input  logic          tx_done,
    output logic [IW-1:0] idx,
    output logic          go,
    output logic          wr_en,
    output logic [31:0]   wr_data,
    output logic          set_txb
);

    tx_state_e   st_q, st_d;
    logic        can_start;
    logic        retire;
    logic [IW:0] nxt;

    assign can_start = tx_en && (txn != '0) && cur_flags[FL_RDY]
                       && (cur_flags[31:16] > 16'd4);
    assign retire    = (st_q == TXS_SEND) && tx_done;
    assign nxt       = {1'b0, idx} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TXS_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TXS_OFF:  if (tx_en) st_d = TXS_SCAN;
            TXS_SCAN: begin
                if (!tx_en)         st_d = TXS_OFF;
                else if (can_start) st_d = TXS_SEND;
            end
            TXS_SEND: if (tx_done) st_d = TXS_SCAN;
            default:  st_d = TXS_OFF;
        endcase
    end

    always_comb begin
        go      = (st_q == TXS_SEND);
        wr_en   = retire;
        wr_data = cur_flags & ~TX_RETIRE_CLR;
        set_txb = retire && cur_flags[FL_IRQ];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (restart) begin
            idx <= '0;
        end else if (retire) begin
            if (cur_flags[FL_WRAP] || nxt >= txn) idx <= '0;
            else                                  idx <= nxt[IW-1:0];
        end
    end

    p_start_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TXS_SEND && $past(st_q) == TXS_SCAN) |->
            $past(tx_en && txn != '0 && cur_flags[FL_RDY] && cur_flags[31:16] > 16'd4));

    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && cur_flags[FL_WRAP] && !restart) |=> (idx == '0));

endmodule

// File: rtl/bd_rx_sched.sv
module bd_rx_sched
    import bd_ring_pkg::*;
#(
    parameter  int NDESC     = 128,
    parameter  int TXN_RESET = 64,
    localparam int IW        = $clog2(NDESC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic [IW:0]   txn,
    input  logic          restart,
    input  logic [15:9]   cur_flags,
    input  logic          rx_frame,
    input  logic [15:0]   rx_len,
    output logic [IW-1:0] idx,
    output logic          ready,
    output logic          wr_en,
    output logic [31:0]   wr_data,
    output logic          set_rxb,
    output logic          set_busy
);

    rx_state_e st_q, st_d;
    logic      ok;
    logic      store;
    logic      busy;

    assign ok    = rx_en && (txn < (IW+1)'(NDESC));
    assign store = (st_q == RXS_LISTEN) && rx_frame &&  cur_flags[FL_RDY];
    assign busy  = (st_q == RXS_LISTEN) && rx_frame && !cur_flags[FL_RDY];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RXS_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RXS_OFF:    if (ok)  st_d = RXS_LISTEN;
            RXS_LISTEN: if (!ok) st_d = RXS_OFF;
            default:    st_d = RXS_OFF;
        endcase
    end

    always_comb begin
        ready    = (st_q == RXS_LISTEN);
        wr_en    = store;
        wr_data  = {rx_len, 1'b0, cur_flags[14:9], 9'b0};
        set_rxb  = store && cur_flags[FL_IRQ];
        set_busy = busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= IW'(TXN_RESET);
        end else if (restart) begin
            idx <= txn[IW-1:0];
        end else if (store) begin
            if (cur_flags[FL_WRAP] || idx == IW'(NDESC - 1)) idx <= txn[IW-1:0];
            else                                              idx <= idx + 1'b1;
        end
    end

    p_rx_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (store && (cur_flags[FL_WRAP] || idx == IW'(NDESC - 1)) && !restart)
            |=> (idx == $past(txn[IW-1:0])));

    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !restart) |=> $stable(idx));

    p_listen_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RXS_LISTEN) |-> $past(ok));

endmodule

// File: rtl/bd_irq_ctrl.sv
module bd_irq_ctrl
    import bd_ring_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SRCW-1:0] set_bits,
    input  logic            clr_we,
    input  logic [SRCW-1:0] clr_bits,
    input  logic            mask_we,
    input  logic [SRCW-1:0] mask_bits,
    output logic [SRCW-1:0] src,
    output logic [SRCW-1:0] mask,
    output logic            irq
);

    logic [SRCW-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src  <= '0;
            mask <= '0;
        end else begin
            src <= (src & ~clr_eff) | set_bits;
            if (mask_we) mask <= mask_bits;
        end
    end

    assign irq = |(src & mask);

    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && set_bits == '0) |=> ((src & $past(clr_bits)) == '0));

endmodule

// File: rtl/bd_ring_mgr.sv
module bd_ring_mgr
    import bd_ring_pkg::*;
#(
    parameter  int NDESC     = 128,
    parameter  int TXN_RESET = 64,
    localparam int IW        = $clog2(NDESC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic          desc_we,
    input  logic [IW:0]   desc_addr,
    input  logic [31:0]   desc_wdata,
    input  logic [IW:0]   desc_raddr,
    output logic [31:0]   desc_rdata,
    input  logic          tx_done,
    output logic          tx_go,
    output logic [15:0]   tx_len,
    output logic [31:0]   tx_ptr,
    output logic [IW-1:0] tx_idx,
    input  logic          rx_frame,
    input  logic [15:0]   rx_len,
    output logic          rx_ready,
    output logic [IW-1:0] rx_idx,
    output logic          irq
);

    logic [1:0]      ctrl_q;
    logic [IW:0]     txn_q;
    logic            ctrl_wr, txn_wr;
    logic            tx_restart, rx_restart;
    logic [31:0]     tx_flags, rx_flags;
    logic            tx_we, rx_we;
    logic [31:0]     tx_wdata, rx_wdata;
    logic            set_txb, set_rxb, set_busy;
    logic [SRCW-1:0] set_bits, src, mask;

    assign ctrl_wr    = reg_we && (reg_sel == SEL_CTRL);
    assign txn_wr     = reg_we && (reg_sel == SEL_TXN);
    assign tx_restart = ctrl_wr && reg_wdata[1] && !ctrl_q[1];
    assign rx_restart = ctrl_wr && reg_wdata[0] && !ctrl_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            txn_q  <= (IW+1)'(TXN_RESET);
        end else begin
            if (ctrl_wr) ctrl_q <= reg_wdata[1:0];
            if (txn_wr && reg_wdata < 32'(NDESC)) txn_q <= reg_wdata[IW:0];
        end
    end

    always_comb begin
        unique case (reg_sel)
            SEL_CTRL: reg_rdata = {30'b0, ctrl_q};
            SEL_SRC:  reg_rdata = 32'(src);
            SEL_MASK: reg_rdata = 32'(mask);
            default:  reg_rdata = 32'(txn_q);
        endcase
    end

    bd_table #(.NDESC(NDESC)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (desc_we),
        .host_addr  (desc_addr),
        .host_wdata (desc_wdata),
        .rd_addr    (desc_raddr),
        .rd_data    (desc_rdata),
        .tx_idx     (tx_idx),
        .tx_flags   (tx_flags),
        .tx_ptr     (tx_ptr),
        .tx_we      (tx_we),
        .tx_wdata   (tx_wdata),
        .rx_idx     (rx_idx),
        .rx_flags   (rx_flags),
        .rx_we      (rx_we),
        .rx_wdata   (rx_wdata)
    );

    bd_tx_sched #(.NDESC(NDESC)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (ctrl_q[1]),
        .txn       (txn_q),
        .restart   (tx_restart),
        .cur_flags (tx_flags),
        .tx_done   (tx_done),
        .idx       (tx_idx),
        .go        (tx_go),
        .wr_en     (tx_we),
        .wr_data   (tx_wdata),
        .set_txb   (set_txb)
    );

    bd_rx_sched #(.NDESC(NDESC), .TXN_RESET(TXN_RESET)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (ctrl_q[0]),
        .txn       (txn_q),
        .restart   (rx_restart),
        .cur_flags (rx_flags[15:9]),
        .rx_frame  (rx_frame),
        .rx_len    (rx_len),
        .idx       (rx_idx),
        .ready     (rx_ready),
        .wr_en     (rx_we),
        .wr_data   (rx_wdata),
        .set_rxb   (set_rxb),
        .set_busy  (set_busy)
    );

    always_comb begin
        set_bits           = '0;
        set_bits[SRC_TXB]  = set_txb;
        set_bits[SRC_RXB]  = set_rxb;
        set_bits[SRC_BUSY] = set_busy;
    end

    bd_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_bits  (set_bits),
        .clr_we    (reg_we && reg_sel == SEL_SRC),
        .clr_bits  (reg_wdata[SRCW-1:0]),
        .mask_we   (reg_we && reg_sel == SEL_MASK),
        .mask_bits (reg_wdata[SRCW-1:0]),
        .src       (src),
        .mask      (mask),
        .irq       (irq)
    );

    assign tx_len = tx_flags[31:16];

endmodule

// File: tb/sim_bd_ring_mgr.sv
`timescale 1ns/1ps
module sim_bd_ring_mgr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        desc_we = 1'b0;
    logic [7:0]  desc_addr = '0;
    logic [31:0] desc_wdata = '0;
    logic [7:0]  desc_raddr = '0;
    logic [31:0] desc_rdata;
    logic        tx_done = 1'b0;
    logic        tx_go;
    logic [15:0] tx_len;
    logic [31:0] tx_ptr;
    logic [6:0]  tx_idx;
    logic        rx_frame = 1'b0;
    logic [15:0] rx_len = '0;
    logic        rx_ready;
    logic [6:0]  rx_idx;
    logic        irq;

    int vecs = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bd_ring_mgr u0 (.*);

    // ---------------- reference model ----------------
    logic [31:0] m_fl [128];
    logic [31:0] m_pt [128];
    int          m_txst, m_rxst, m_txi, m_rxi, m_txn;
    logic [1:0]  m_ctrl;
    logic [4:0]  m_src, m_mask;

    logic [31:0] tf, rf;
    int          nti, nri, ntst, nrst, o_txn;
    logic [1:0]  o_ctrl;
    logic [4:0]  setb, nsrc;
    bit          txw, rxw;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) begin
                m_fl[i] = '0;
                m_pt[i] = '0;
            end
            m_txst = 0; m_rxst = 0; m_txi = 0; m_rxi = 64; m_txn = 64;
            m_ctrl = '0; m_src = '0; m_mask = '0;
        end else begin
            o_ctrl = m_ctrl; o_txn = m_txn;
            tf = m_fl[m_txi]; rf = m_fl[m_rxi];
            nti = m_txi; nri = m_rxi; ntst = m_txst; nrst = m_rxst;
            setb = '0; txw = 0; rxw = 0;
            case (m_txst)
                0: if (o_ctrl[1]) ntst = 1;
                1: if (!o_ctrl[1]) ntst = 0;
                   else if (o_txn != 0 && tf[15] && tf[31:16] > 4) ntst = 2;
                default: if (tx_done) begin
                    ntst = 1; txw = 1;
                    if (tf[14]) setb[0] = 1'b1;
                    if (tf[13] || m_txi + 1 >= o_txn) nti = 0;
                    else nti = m_txi + 1;
                end
            endcase
            case (m_rxst)
                0: if (o_ctrl[0] && o_txn < 128) nrst = 1;
                default: begin
                    if (rx_frame) begin
                        if (rf[15]) begin
                            rxw = 1;
                            if (rf[14]) setb[2] = 1'b1;
                            if (rf[13] || m_rxi == 127) nri = o_txn;
                            else nri = m_rxi + 1;
                        end else setb[4] = 1'b1;
                    end
                    if (!(o_ctrl[0] && o_txn < 128)) nrst = 0;
                end
            endcase
            if (desc_we) begin
                if (desc_addr[0]) m_pt[desc_addr[7:1]] = desc_wdata;
                else              m_fl[desc_addr[7:1]] = desc_wdata;
            end
            if (txw) m_fl[m_txi] = tf & ~32'h0000_81FF;
            if (rxw) m_fl[m_rxi] = {rx_len, 1'b0, rf[14:9], 9'b0};
            nsrc = m_src;
            if (reg_we) begin
                case (reg_sel)
                    2'd0: begin
                        if (reg_wdata[1] && !o_ctrl[1]) nti = 0;
                        if (reg_wdata[0] && !o_ctrl[0]) nri = o_txn;
                        m_ctrl = reg_wdata[1:0];
                    end
                    2'd1: nsrc = nsrc & ~reg_wdata[4:0];
                    2'd2: m_mask = reg_wdata[4:0];
                    default: if (reg_wdata < 128) m_txn = int'(reg_wdata);
                endcase
            end
            m_src = nsrc | setb;
            m_txi = nti; m_rxi = nri; m_txst = ntst; m_rxst = nrst;
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_reg(logic [1:0] s);
        case (s)
            2'd0:    return {30'b0, m_ctrl};
            2'd1:    return 32'(m_src);
            2'd2:    return 32'(m_mask);
            default: return 32'(m_txn);
        endcase
    endfunction

    // per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3", "tx_go", 32'(tx_go), 32'(m_txst == 2));
            chk("R3", "tx_len", 32'(tx_len), 32'(m_fl[m_txi][31:16]));
            chk("R3", "tx_ptr", tx_ptr, m_pt[m_txi]);
            chk("R5", "tx_idx", 32'(tx_idx), 32'(m_txi));
            chk("R7", "rx_idx", 32'(rx_idx), 32'(m_rxi));
            chk("R8", "rx_ready", 32'(rx_ready), 32'(m_rxst == 1));
            chk("R9", "irq", 32'(irq), 32'(|(m_src & m_mask)));
            chk("R2", "reg_rdata", reg_rdata, m_reg(reg_sel));
            chk("R4", "desc_rdata", desc_rdata,
                desc_raddr[0] ? m_pt[desc_raddr[7:1]] : m_fl[desc_raddr[7:1]]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wr_reg(logic [1:0] s, logic [31:0] d);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic wr_desc(logic [7:0] a, logic [31:0] d);
        desc_we = 1'b1; desc_addr = a; desc_wdata = d;
        step();
        desc_we = 1'b0;
    endtask

    task automatic pulse_tx_done();
        tx_done = 1'b1; step(); tx_done = 1'b0;
    endtask

    task automatic pulse_rx(logic [15:0] len);
        rx_frame = 1'b1; rx_len = len; step(); rx_frame = 1'b0;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        reg_sel = 2'd3;
        #1;
        chk("R1", "reset count", reg_rdata, 32'h40);
        chk("R1", "reset tx_idx", 32'(tx_idx), 32'd0);
        chk("R1", "reset rx_idx", 32'(rx_idx), 32'h40);
        chk("R1", "reset irq", 32'(irq), 32'd0);
        chk("R1", "reset desc", desc_rdata, 32'd0);

        // R2: count writes
        wr_reg(2'd3, 32'h80);
        chk("R2", "count after 0x80", reg_rdata, 32'h40);
        wr_reg(2'd3, 32'h1_0005);
        chk("R2", "count after large", reg_rdata, 32'h40);
        wr_reg(2'd3, 32'd16);
        chk("R2", "count after 16", reg_rdata, 32'd16);

        // transmit ring
        wr_desc(8'd0, 32'h003C_C0FF);
        wr_desc(8'd1, 32'h0000_1000);
        wr_desc(8'd2, 32'h0004_8000);
        wr_reg(2'd2, 32'h15);
        wr_reg(2'd0, 32'h2);
        step(); step();
        chk("R3", "tx_go on ready desc", 32'(tx_go), 32'd1);
        chk("R3", "tx_len", 32'(tx_len), 32'd60);
        pulse_tx_done();
        desc_raddr = 8'd0; #1;
        chk("R4", "retired flags", desc_rdata, 32'h003C_4000);
        chk("R5", "tx_idx advance", 32'(tx_idx), 32'd1);
        chk("R9", "irq on TXB", 32'(irq), 32'd1);
        step(); step();
        chk("R3", "no start len 4", 32'(tx_go), 32'd0);
        wr_desc(8'd2, 32'h0005_A000);
        step();
        chk("R11", "start after host write", 32'(tx_go), 32'd1);
        pulse_tx_done();
        chk("R5", "tx wrap bit", 32'(tx_idx), 32'd0);
        wr_reg(2'd1, 32'h1);
        chk("R9", "w1c clears", 32'(irq), 32'd0);

        // R8: receive disabled
        pulse_rx(16'd100);
        reg_sel = 2'd1; #1;
        chk("R8", "no busy when off", reg_rdata, 32'd0);
        chk("R8", "rx_idx unchanged", 32'(rx_idx), 32'h40);

        // receive ring
        wr_desc(8'd32, 32'h0000_C0FF);
        wr_reg(2'd0, 32'h3);
        chk("R10", "rx restart to N", 32'(rx_idx), 32'd16);
        step();
        pulse_rx(16'd100);
        desc_raddr = 8'd32; reg_sel = 2'd1; #1;
        chk("R7", "stored flags", desc_rdata, 32'h0064_4000);
        chk("R7", "rx_idx advance", 32'(rx_idx), 32'd17);
        chk("R9", "RXB set", reg_rdata, 32'h4);
        pulse_rx(16'd77);
        desc_raddr = 8'd34; #1;
        chk("R6", "busy source", reg_rdata, 32'h14);
        chk("R6", "busy rx_idx", 32'(rx_idx), 32'd17);
        chk("R6", "busy desc kept", desc_rdata, 32'd0);

        // end-of-table wrap
        wr_desc(8'd254, 32'h0000_8000);
        wr_reg(2'd3, 32'd127);
        wr_reg(2'd0, 32'h2);
        wr_reg(2'd0, 32'h3);
        chk("R10", "rx restart to 127", 32'(rx_idx), 32'd127);
        wr_reg(2'd3, 32'd20);
        step();
        pulse_rx(16'd64);
        desc_raddr = 8'd254; #1;
        chk("R7", "wrap at 127", 32'(rx_idx), 32'd20);
        chk("R7", "stored at 127", desc_rdata, 32'h0040_0000);

        // wrap-bit on receive
        wr_desc(8'd40, 32'h0000_A000);
        wr_reg(2'd3, 32'd5);
        pulse_rx(16'd200);
        chk("R7", "rx wrap bit", 32'(rx_idx), 32'd5);

        repeat (10) step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule